// File: doc/BRIEF.md
# Clock Source Switch Controller

This block decides which source drives the CPU clock of a small microcontroller. Three sources are available: an always-running high-speed internal oscillator, a high-speed main clock (crystal amplifier or direct external input) and a low-speed subsystem clock (crystal amplifier or direct external input). Software configures the block through a simple 8-bit register port. The port has a write-once oscillator mode register, a stop register, a settling-time code and a clock-select register. The block drives a 2-bit source code to the clock multiplexer, and control levels to the analog oscillator amplifiers.

Oscillator outputs are modelled as single-cycle enable pulses (`main_tick`, `sub_tick`) in the one system clock domain. A settling counter counts main-oscillator pulses after the main stop bit is cleared, and software reads its progress as a thermometer code. A similar fixed-length counter guards the subsystem oscillator. A request to switch is always stored. The active source only follows the request once the requested source is enabled, running and, in crystal mode, settled. In external-input mode the settling check is skipped.

Top module: `clk_switch_ctrl`

## Requirements
- R1: After reset the active source is the internal oscillator (`cpu_clk_sel` = 2'b00, with 2'b01 = main and 2'b10 = subsystem). The mode register reads 0x00, the stop register reads 0x03, the clock-select register reads 0x00, and both amplifier outputs are low.
- R2: The mode register (address 0) takes the first write after reset and ignores every later write. Its fields are: bit0 main external input, bit1 main oscillator enable, bit2 main high frequency range, bit3 subsystem external input, bit4 subsystem oscillator enable, bits 6:5 subsystem drive mode. `main_gain_hi` follows bit2.
- R3: The stop register is at address 1, with bit0 the main stop and bit1 the subsystem stop. An amplifier output is high only when its oscillator is enabled, its stop bit is 0 and it is not in external-input mode.
- R4: The main settling counter counts `main_tick` pulses while the main stop bit is 0. It is held at zero while the stop bit is 1, so it restarts from zero on every 1-to-0 change of that bit. It saturates at its maximum value.
- R5: The status register (address 3) bit i is 1 when the counter has reached 2^(i+1) pulses. The 3-bit settling code is written at address 2.
- R6: In crystal mode a main-clock request becomes active only when the oscillator is enabled, the main stop bit is 0 and status bit [code] is 1. With the oscillator disabled, the request never becomes active.
- R7: In main external-input mode the request becomes active one cycle after it is written, with no settling pulses needed.
- R8: A subsystem request becomes active only when the subsystem is enabled, its stop bit is 0, and either it is in external-input mode or 16 `sub_tick` pulses have been counted since the stop bit was cleared.
- R9: In subsystem external-input mode `sub_drive` is 2'b00 whatever the drive-mode field holds. Otherwise `sub_drive` follows the field.
- R10: A write that sets the stop bit of the active or requested source leaves that bit at 0.
- R11: Clock-select register (address 4): bit0 requests main and bit1 requests subsystem, with the subsystem winning when both are set. Bit4 reads 1 while main is active, and bit5 reads 1 while the subsystem is active. With no request set, the internal oscillator is active on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational from address) |
| main_tick | input | 1 | One pulse per main oscillator period |
| sub_tick | input | 1 | One pulse per subsystem oscillator period |
| cpu_clk_sel | output | 2 | Active source code for the clock multiplexer |
| main_amp_on | output | 1 | Enable of the main crystal amplifier |
| main_gain_hi | output | 1 | Main amplifier high frequency range |
| sub_amp_on | output | 1 | Enable of the subsystem crystal amplifier |
| sub_drive | output | 2 | Subsystem amplifier drive mode |

## Verification
The bench holds the main oscillator pulses off and shows that the status stays at zero. It then switches to main before the chosen threshold is reached; a design that ignored the settling code would switch early. It toggles the main stop bit mid-count and expects the status to read zero again, which catches a counter that only pauses instead of restarting. It also sets the stop bit of the running source and repeats the mode write; a design that stopped its own clock or accepted a second configuration would show the wrong readback. The external-input runs use no pulses at all, so a design that kept the settling check in those modes would never switch.

// File: rtl/csw_pkg.sv
package csw_pkg;

   typedef enum logic [1:0] {
      SRC_HSI  = 2'b00,
      SRC_MAIN = 2'b01,
      SRC_SUB  = 2'b10
   } src_e;

   // register addresses
   localparam int unsigned A_MODE = 0;
   localparam int unsigned A_STOP = 1;
   localparam int unsigned A_CODE = 2;
   localparam int unsigned A_STAT = 3;
   localparam int unsigned A_SEL  = 4;

   // mode register field positions
   localparam int unsigned M_MAIN_EXT = 0;
   localparam int unsigned M_MAIN_EN  = 1;
   localparam int unsigned M_MAIN_HI  = 2;
   localparam int unsigned M_SUB_EXT  = 3;
   localparam int unsigned M_SUB_EN   = 4;
   localparam int unsigned M_SUB_DRV  = 5;

endpackage

// File: rtl/csw_settle.sv
module csw_settle #(
   parameter int unsigned NUM_THR   = 8,
   parameter int unsigned THR_SHIFT = 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               hold_clr,
   input  logic               tick,
   output logic [NUM_THR-1:0] therm
);
   localparam int unsigned CNT_W = THR_SHIFT + NUM_THR;

   if (NUM_THR < 1) begin : g_bad_thr
      $error("csw_settle: NUM_THR must be at least 1");
   end
   if (CNT_W > 31) begin : g_bad_w
      $error("csw_settle: counter width too large");
   end

   logic [CNT_W-1:0] cnt_q;
   logic             sat;

   assign sat = &cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (hold_clr)
         cnt_q <= '0;
      else if (tick && !sat)
         cnt_q <= cnt_q + 1'b1;
   end

   for (genvar i = 0; i < NUM_THR; i++) begin : g_thr
      localparam logic [CNT_W-1:0] LIM = CNT_W'(1) << (THR_SHIFT + i);
      assign therm[i] = (cnt_q >= LIM);
   end

   // R4
   sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sat && !hold_clr) |=> sat);

   // R4
   clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hold_clr |=> (cnt_q == '0));

endmodule

// File: rtl/csw_regs.sv
module csw_regs
   import csw_pkg::*;
#(
   parameter int unsigned ADDR_W = 3,
   parameter int unsigned DATA_W = 8,
   parameter int unsigned CODE_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   input  src_e              act,
   output logic [DATA_W-1:0] mode_q,
   output logic              main_stop,
   output logic              sub_stop,
   output logic [CODE_W-1:0] code_q,
   output logic              main_req,
   output logic              sub_req
);
   if (DATA_W != 8) begin : g_bad_dw
      $error("csw_regs: DATA_W must be 8");
   end
   if (CODE_W > DATA_W) begin : g_bad_cw
      $error("csw_regs: code field wider than data bus");
   end

   logic mode_locked;
   logic hit_mode, hit_stop, hit_code, hit_sel;
   logic guard_main, guard_sub;

   assign hit_mode = wr_en && (addr == ADDR_W'(A_MODE));
   assign hit_stop = wr_en && (addr == ADDR_W'(A_STOP));
   assign hit_code = wr_en && (addr == ADDR_W'(A_CODE));
   assign hit_sel  = wr_en && (addr == ADDR_W'(A_SEL));

   // a source in use or requested may not be stopped
   assign guard_main = (act == SRC_MAIN) || main_req;
   assign guard_sub  = (act == SRC_SUB)  || sub_req;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q      <= '0;
         mode_locked <= 1'b0;
      end else if (hit_mode && !mode_locked) begin
         mode_q      <= wdata;
         mode_locked <= 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         main_stop <= 1'b1;
         sub_stop  <= 1'b1;
      end else if (hit_stop) begin
         main_stop <= (guard_main && wdata[0]) ? main_stop : wdata[0];
         sub_stop  <= (guard_sub  && wdata[1]) ? sub_stop  : wdata[1];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         code_q <= '0;
      else if (hit_code)
         code_q <= wdata[CODE_W-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         main_req <= 1'b0;
         sub_req  <= 1'b0;
      end else if (hit_sel) begin
         main_req <= wdata[0];
         sub_req  <= wdata[1];
      end
   end

   // R2
   mode_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mode_locked |=> ($stable(mode_q) && mode_locked));

   // R10
   main_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (guard_main && !main_stop) |=> !main_stop);

   // R10
   sub_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (guard_sub && !sub_stop) |=> !sub_stop);

endmodule

// File: rtl/csw_select.sv
module csw_select
   import csw_pkg::*;
#(
   parameter bit SUB_PRIORITY = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic main_req,
   input  logic sub_req,
   input  logic main_ok,
   input  logic sub_ok,
   output src_e act
);
   src_e target;
   logic target_ok;
   src_e act_q;

   if (SUB_PRIORITY) begin : g_sub_first
      always_comb begin
         if (sub_req)       target = SRC_SUB;
         else if (main_req) target = SRC_MAIN;
         else               target = SRC_HSI;
      end
   end else begin : g_main_first
      always_comb begin
         if (main_req)      target = SRC_MAIN;
         else if (sub_req)  target = SRC_SUB;
         else               target = SRC_HSI;
      end
   end

   always_comb begin
      case (target)
         SRC_MAIN: target_ok = main_ok;
         SRC_SUB:  target_ok = sub_ok;
         default:  target_ok = 1'b1;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         act_q <= SRC_HSI;
      else if (target_ok)
         act_q <= target;
   end

   assign act = act_q;

   // R6
   main_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (act_q == SRC_MAIN && $past(act_q) != SRC_MAIN) |-> $past(main_ok));

   // R8
   sub_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (act_q == SRC_SUB && $past(act_q) != SRC_SUB) |-> $past(sub_ok));

   // R11
   idle_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!main_req && !sub_req) |=> (act_q == SRC_HSI));

endmodule

// File: rtl/clk_switch_ctrl.sv
module clk_switch_ctrl
   import csw_pkg::*;
#(
   parameter int unsigned ADDR_W       = 3,
   parameter int unsigned DATA_W       = 8,
   parameter int unsigned NUM_THR      = 8,
   parameter int unsigned THR_SHIFT    = 1,
   parameter int unsigned SUB_THR_IDX  = 3,
   parameter bit          SUB_PRIORITY = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              main_tick,
   input  logic              sub_tick,
   output logic [1:0]        cpu_clk_sel,
   output logic              main_amp_on,
   output logic              main_gain_hi,
   output logic              sub_amp_on,
   output logic [1:0]        sub_drive
);
   localparam int unsigned CODE_W  = (NUM_THR > 1) ? $clog2(NUM_THR) : 1;
   localparam int unsigned SUB_NTH = SUB_THR_IDX + 1;

   if (NUM_THR > DATA_W) begin : g_bad_thr
      $error("clk_switch_ctrl: status does not fit the data bus");
   end
   if (SUB_THR_IDX >= NUM_THR) begin : g_bad_sub
      $error("clk_switch_ctrl: SUB_THR_IDX out of range");
   end
   if (ADDR_W < 3) begin : g_bad_aw
      $error("clk_switch_ctrl: ADDR_W too small for the register map");
   end

   logic [DATA_W-1:0]  mode_q;
   logic               main_stop, sub_stop, main_req, sub_req;
   logic [CODE_W-1:0]  code_q;
   logic [NUM_THR-1:0] main_therm;
   logic [SUB_NTH-1:0] sub_therm;
   logic               main_settled, sub_settled, main_ok, sub_ok;
   logic               m_ext, m_en, s_ext, s_en;
   src_e               act;

   csw_regs #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W),
      .CODE_W (CODE_W)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (bus_wr),
      .addr      (bus_addr),
      .wdata     (bus_wdata),
      .act       (act),
      .mode_q    (mode_q),
      .main_stop (main_stop),
      .sub_stop  (sub_stop),
      .code_q    (code_q),
      .main_req  (main_req),
      .sub_req   (sub_req)
   );

   csw_settle #(
      .NUM_THR   (NUM_THR),
      .THR_SHIFT (THR_SHIFT)
   ) u_main_settle (
      .clk      (clk),
      .rst_n    (rst_n),
      .hold_clr (main_stop),
      .tick     (main_tick),
      .therm    (main_therm)
   );

   csw_settle #(
      .NUM_THR   (SUB_NTH),
      .THR_SHIFT (THR_SHIFT)
   ) u_sub_settle (
      .clk      (clk),
      .rst_n    (rst_n),
      .hold_clr (sub_stop),
      .tick     (sub_tick),
      .therm    (sub_therm)
   );

   assign m_ext = mode_q[M_MAIN_EXT];
   assign m_en  = mode_q[M_MAIN_EN];
   assign s_ext = mode_q[M_SUB_EXT];
   assign s_en  = mode_q[M_SUB_EN];

   always_comb begin
      if (32'(code_q) < NUM_THR)
         main_settled = main_therm[code_q];
      else
         main_settled = main_therm[NUM_THR-1];
   end

   // thermometer: all bits set means the top threshold is reached
   assign sub_settled = &sub_therm;

   assign main_ok = m_en && !main_stop && (m_ext || main_settled);
   assign sub_ok  = s_en && !sub_stop  && (s_ext || sub_settled);

   csw_select #(
      .SUB_PRIORITY (SUB_PRIORITY)
   ) u_select (
      .clk      (clk),
      .rst_n    (rst_n),
      .main_req (main_req),
      .sub_req  (sub_req),
      .main_ok  (main_ok),
      .sub_ok   (sub_ok),
      .act      (act)
   );

   assign cpu_clk_sel  = act;
   assign main_amp_on  = m_en && !m_ext && !main_stop;
   assign main_gain_hi = mode_q[M_MAIN_HI];
   assign sub_amp_on   = s_en && !s_ext && !sub_stop;
   assign sub_drive    = s_ext ? 2'b00 : mode_q[M_SUB_DRV +: 2];

   always_comb begin
      bus_rdata = '0;
      case (32'(bus_addr))
         A_MODE: bus_rdata = mode_q;
         A_STOP: bus_rdata = DATA_W'({sub_stop, main_stop});
         A_CODE: bus_rdata = DATA_W'(code_q);
         A_STAT: bus_rdata = DATA_W'(main_therm);
         A_SEL:  bus_rdata = DATA_W'({act == SRC_SUB, act == SRC_MAIN,
                                      2'b00, sub_req, main_req});
         default: bus_rdata = '0;
      endcase
   end

   // R10
   main_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (act == SRC_MAIN) |-> !main_stop);

   // R10
   sub_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (act == SRC_SUB) |-> !sub_stop);

   // R9
   ext_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      s_ext |-> (sub_drive == 2'b00));

endmodule

// File: tb/clk_switch_ctrl_test.sv
module clk_switch_ctrl_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_wr = 1'b0;
   logic [2:0] bus_addr = '0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic       main_tick = 1'b1;
   logic       sub_tick = 1'b1;
   logic [1:0] cpu_clk_sel;
   logic       main_amp_on, main_gain_hi, sub_amp_on;
   logic [1:0] sub_drive;

   int n_chk = 0;
   int n_bad = 0;

   always #4 clk = ~clk;

   clk_switch_ctrl uut (
      .clk          (clk),
      .rst_n        (rst_n),
      .bus_wr       (bus_wr),
      .bus_addr     (bus_addr),
      .bus_wdata    (bus_wdata),
      .bus_rdata    (bus_rdata),
      .main_tick    (main_tick),
      .sub_tick     (sub_tick),
      .cpu_clk_sel  (cpu_clk_sel),
      .main_amp_on  (main_amp_on),
      .main_gain_hi (main_gain_hi),
      .sub_amp_on   (sub_amp_on),
      .sub_drive    (sub_drive)
   );

   task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %02h expected %02h", tag, got, exp);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [7:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; main_tick = 1'b1; sub_tick = 1'b1;
      idle(2);
      rst_n = 1'b1;
      idle(1);
   endtask

   task automatic t_reset();
      logic [7:0] v;
      do_reset();
      chk("R1 sel", {6'b0, cpu_clk_sel}, 8'h00);
      rd(3'd0, v); chk("R1 mode", v, 8'h00);
      rd(3'd1, v); chk("R1 stop", v, 8'h03);
      rd(3'd4, v); chk("R1 clksel", v, 8'h00);
      chk("R1 amps", {6'b0, main_amp_on, sub_amp_on}, 8'h00);
   endtask

   task automatic t_write_once();
      logic [7:0] v;
      do_reset();
      wr(3'd0, 8'h06);
      rd(3'd0, v); chk("R2 first write", v, 8'h06);
      wr(3'd0, 8'h18);
      rd(3'd0, v); chk("R2 second write ignored", v, 8'h06);
      chk("R2 gain", {7'b0, main_gain_hi}, 8'h01);
      // crystal mode but main stopped: amp off (R3)
      chk("R3 amp off when stopped", {7'b0, main_amp_on}, 8'h00);
   endtask

   task automatic t_main_disabled();
      do_reset();
      wr(3'd1, 8'h02);
      wr(3'd4, 8'h01);
      idle(40);
      chk("R6 disabled osc stays internal", {6'b0, cpu_clk_sel}, 8'h00);
   endtask

   task automatic t_main_crystal();
      logic [7:0] v;
      do_reset();
      wr(3'd0, 8'h02);
      wr(3'd2, 8'h03);
      main_tick = 1'b0;
      wr(3'd1, 8'h02);
      chk("R3 main amp on", {7'b0, main_amp_on}, 8'h01);
      idle(10);
      rd(3'd3, v); chk("R4 no ticks no count", v, 8'h00);
      main_tick = 1'b1;
      idle(10);
      rd(3'd3, v); chk("R5 status after 10 ticks", v, 8'h07);
      wr(3'd1, 8'h03);
      wr(3'd1, 8'h02);
      rd(3'd3, v); chk("R4 restart after stop toggle", v, 8'h00);
      wr(3'd4, 8'h01);
      idle(5);
      chk("R6 not settled yet", {6'b0, cpu_clk_sel}, 8'h00);
      rd(3'd4, v); chk("R11 request stored", v, 8'h01);
      idle(30);
      chk("R6 switched after settle", {6'b0, cpu_clk_sel}, 8'h01);
      rd(3'd4, v); chk("R11 main active flag", v, 8'h11);
      wr(3'd1, 8'h03);
      rd(3'd1, v); chk("R10 main stop ignored", v, 8'h02);
      idle(600);
      rd(3'd3, v); chk("R4 saturated", v, 8'hFF);
      chk("R10 still on main", {6'b0, cpu_clk_sel}, 8'h01);
      wr(3'd4, 8'h00);
      idle(1);
      chk("R11 back to internal", {6'b0, cpu_clk_sel}, 8'h00);
   endtask

   task automatic t_external();
      logic [7:0] v;
      do_reset();
      main_tick = 1'b0; sub_tick = 1'b0;
      wr(3'd0, 8'h1B);
      wr(3'd2, 8'h07);
      wr(3'd1, 8'h00);
      chk("R3 ext amps off", {6'b0, main_amp_on, sub_amp_on}, 8'h00);
      wr(3'd4, 8'h01);
      idle(1);
      chk("R7 main external bypass", {6'b0, cpu_clk_sel}, 8'h01);
      wr(3'd4, 8'h03);
      idle(1);
      chk("R11 sub priority", {6'b0, cpu_clk_sel}, 8'h02);
      rd(3'd4, v); chk("R11 sub active flag", v, 8'h23);
      wr(3'd4, 8'h01);
      idle(1);
      chk("R8 back to main", {6'b0, cpu_clk_sel}, 8'h01);
   endtask

   task automatic t_sub_crystal();
      logic [7:0] v;
      do_reset();
      wr(3'd0, 8'h50);
      chk("R9 drive follows field", {6'b0, sub_drive}, 8'h02);
      sub_tick = 1'b0;
      wr(3'd1, 8'h01);
      chk("R3 sub amp on", {7'b0, sub_amp_on}, 8'h01);
      wr(3'd4, 8'h02);
      idle(10);
      chk("R8 sub not settled", {6'b0, cpu_clk_sel}, 8'h00);
      sub_tick = 1'b1;
      idle(12);
      chk("R8 sub still settling", {6'b0, cpu_clk_sel}, 8'h00);
      idle(10);
      chk("R8 sub switched", {6'b0, cpu_clk_sel}, 8'h02);
      wr(3'd1, 8'h03);
      rd(3'd1, v); chk("R10 sub stop ignored", v, 8'h01);
   endtask

   task automatic t_sub_external();
      do_reset();
      sub_tick = 1'b0;
      wr(3'd0, 8'h78);
      chk("R9 drive ignored external", {6'b0, sub_drive}, 8'h00);
      wr(3'd1, 8'h01);
      wr(3'd4, 8'h02);
      idle(1);
      chk("R8 sub external bypass", {6'b0, cpu_clk_sel}, 8'h02);
   endtask

   initial begin
      t_reset();
      t_write_once();
      t_main_disabled();
      t_main_crystal();
      t_external();
      t_sub_crystal();
      t_sub_external();
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      #(8 * 20000);
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

endmodule